// File: doc/BRIEF.md
# Lagged Redundant-Result Delay Buffer Checker

This block sits between two copies of one instruction stream that run with a lag between them. The leading copy retires each result as soon as it is ready and pushes it, with its destination tag, into a first-in first-out delay buffer. The trailing copy later offers its own result for the same instruction. The checker compares that result and tag with the oldest entry in the buffer. If they agree, the trailing copy may commit and the entry is removed, so the states the trailing copy has committed always form a checked recovery point.

If they disagree, the checker raises a one-cycle error pulse and halts both ports. Surrounding logic rolls both copies back to the trailing copy's last committed state and then pulses `recover`. This empties the buffer and lets normal operation resume. A full buffer stalls the leading copy, and an empty buffer keeps the trailing copy from committing. An occupancy output shows how far the two copies are apart.

Top module: `lag_check_buf`

## Requirements
- R1: After reset, `occupancy` is 0, `lead_ready` is 1, `trail_commit` is 0 and `mismatch_err` is 0.
- R2: When `lead_valid` and `lead_ready` are both high at a clock edge, the data and tag are appended to the buffer, and `occupancy` rises by one unless an entry is also removed in that cycle.
- R3: `trail_commit` is high in the same cycle that `trail_valid` is high, the buffer is not empty, no halt is in force, and `trail_data` and `trail_tag` both equal the oldest entry. The entry is removed at that clock edge.
- R4: Entries are compared in the order in which they were pushed.
- R5: While `occupancy` equals DEPTH, `lead_ready` is 0, and a push attempt leaves `occupancy` unchanged.
- R6: While the buffer is empty, `trail_commit` stays 0 whatever is offered on the trailing port.
- R7: When the trailing result differs from the oldest entry in data, in tag, or in both, `trail_commit` is 0 and the entry is kept. `mismatch_err` is high for exactly the one cycle after that edge.
- R8: From the pulse until `recover`, the block is halted: `lead_ready` and `trail_commit` are 0, and `occupancy` does not change.
- R9: A cycle with `recover` high empties the buffer and clears the halt. In that cycle `lead_ready` and `trail_commit` are 0 and nothing is pushed. In the next cycle `occupancy` is 0.
- R10: A push and a commit at the same edge leave `occupancy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading copy offers a retired result |
| lead_data | input | DATA_W | Leading result value |
| lead_tag | input | TAG_W | Leading destination tag |
| lead_ready | output | 1 | Buffer accepts a push this cycle |
| trail_valid | input | 1 | Trailing copy offers a completed result |
| trail_data | input | DATA_W | Trailing result value |
| trail_tag | input | TAG_W | Trailing destination tag |
| trail_commit | output | 1 | Trailing result matched; it may commit |
| mismatch_err | output | 1 | One-cycle pulse after a failed comparison |
| recover | input | 1 | Flush buffer and leave the halted state |
| occupancy | output | $clog2(DEPTH+1) | Number of buffered entries |

## Verification
A wrong pointer or count shows up on the trailing port within one cycle. A good result is then refused, or a stale entry is compared, which gives a false error pulse in the next cycle. It also shows on `occupancy`, or as a `lead_ready` that drops too early or too late near the full boundary. A halt flag that fails to stick shows as a port reopening before `recover`. A flush that is missed shows as a nonzero `occupancy` in the cycle after `recover`. The bench uses a depth of four and fills and drains the buffer completely. It flips every data bit and every tag bit in turn to force mismatches, and it interleaves pushes with commits.

// File: rtl/lag_check_buf.sv
module lag_check_buf #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lead_valid,
  input  logic [DATA_W-1:0]          lead_data,
  input  logic [TAG_W-1:0]           lead_tag,
  output logic                       lead_ready,
  input  logic                       trail_valid,
  input  logic [DATA_W-1:0]          trail_data,
  input  logic [TAG_W-1:0]           trail_tag,
  output logic                       trail_commit,
  output logic                       mismatch_err,
  input  logic                       recover,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [TAG_W-1:0]  mem_t [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;
  logic              halted, err_q;

  wire full   = (count == CNT_W'(DEPTH));
  wire empty  = (count == '0);
  wire active = !halted && !recover;
  wire head_match = (mem_d[rd_ptr] == trail_data) && (mem_t[rd_ptr] == trail_tag);
  wire push   = lead_valid && lead_ready;
  wire miss   = active && trail_valid && !empty && !head_match;

  assign lead_ready   = active && !full;
  assign trail_commit = active && trail_valid && !empty && head_match;
  assign mismatch_err = err_q;
  assign occupancy    = count;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= lead_data;
      mem_t[wr_ptr] <= lead_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      halted <= 1'b0;
      err_q  <= 1'b0;
    end else if (recover) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      halted <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= miss;
      if (miss) halted <= 1'b1;
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (trail_commit) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, trail_commit})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !trail_commit) |=> occupancy == CNT_W'($past(occupancy) + 1'b1));
  a_r3_commit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_commit && !push) |=> occupancy == CNT_W'($past(occupancy) - 1'b1));
  a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (push && trail_commit) |=> $stable(occupancy));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err |=> !mismatch_err);
  a_r8_halt_ports: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err |-> (!lead_ready && !trail_commit));
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (occupancy == '0 && !mismatch_err));
endmodule

// File: tb/test_lag_check_buf.sv
`timescale 1ns/1ps
module test_lag_check_buf;
  localparam int DW = 8, TW = 3, D = 4;
  logic clk = 0, rst_n = 0;
  logic lead_valid = 0, trail_valid = 0, recover = 0;
  logic [DW-1:0] lead_data = 0, trail_data = 0;
  logic [TW-1:0] lead_tag = 0, trail_tag = 0;
  logic lead_ready, trail_commit, mismatch_err;
  logic [2:0] occupancy;
  int total = 0, bad = 0;
  int qd[$], qt[$];
  bit halted_m = 0;

  always #2.5 clk = ~clk;

  lag_check_buf #(.DATA_W(DW), .TAG_W(TW), .DEPTH(D)) i_lag_check_buf (
    .clk, .rst_n, .lead_valid, .lead_data, .lead_tag, .lead_ready,
    .trail_valid, .trail_data, .trail_tag, .trail_commit,
    .mismatch_err, .recover, .occupancy);

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit lv, int ld, int lt, bit tv, int td, int tt, bit rc, string req);
    bit er, ec, em, full;
    lead_valid = lv; lead_data = DW'(ld); lead_tag = TW'(lt);
    trail_valid = tv; trail_data = DW'(td); trail_tag = TW'(tt); recover = rc;
    #1;
    full = (qd.size() >= D);
    er = !halted_m && !rc && !full;
    ec = !halted_m && !rc && tv && qd.size() > 0 && td == qd[0] && tt == qt[0];
    em = !halted_m && !rc && tv && qd.size() > 0 && !(td == qd[0] && tt == qt[0]);
    chk(lead_ready == er, {req, " lead_ready"}, lead_ready, er);
    chk(trail_commit == ec, {req, " trail_commit"}, trail_commit, ec);
    @(posedge clk);
    if (rc) begin
      qd.delete(); qt.delete(); halted_m = 0;
    end else begin
      if (ec) begin void'(qd.pop_front()); void'(qt.pop_front()); end
      if (lv && er) begin qd.push_back(ld); qt.push_back(lt); end
      if (em) halted_m = 1;
    end
    @(negedge clk);
    chk(mismatch_err == (em && !rc), {req, " mismatch_err"}, mismatch_err, em && !rc);
    chk(occupancy == qd.size(), {req, " occupancy"}, occupancy, qd.size());
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(occupancy == 0, "R1 occupancy", occupancy, 0);
    chk(lead_ready == 1, "R1 lead_ready", lead_ready, 1);
    chk(trail_commit == 0, "R1 trail_commit", trail_commit, 0);
    chk(mismatch_err == 0, "R1 mismatch_err", mismatch_err, 0);
    @(negedge clk);
    // R6: empty buffer, trailing offers anything
    cyc(0, 0, 0, 1, 0, 0, 0, "R6 empty");
    // R2 fill, R5 full stall
    for (int i = 0; i < D; i++) cyc(1, i*37+5, i, 0, 0, 0, 0, "R2 fill");
    for (int i = 0; i < 2; i++) cyc(1, 99, 7, 0, 0, 0, 0, "R5 full");
    // R3/R4 drain in order
    for (int i = 0; i < D; i++) cyc(0, 0, 0, 1, i*37+5, i, 0, "R4 drain");
    cyc(0, 0, 0, 1, 5, 0, 0, "R6 drained");
    // R10 concurrent push and commit
    cyc(1, 11, 1, 0, 0, 0, 0, "R2 prime");
    for (int i = 0; i < 6; i++) cyc(1, 20+i, (i+2)%8, 1, qd[0], qt[0], 0, "R10 overlap");
    for (int i = 0; i < 3; i++) cyc(1, 50+i, i, 0, 0, 0, 0, "R2 top");
    cyc(1, 77, 2, 1, qd[0], qt[0], 0, "R10 at full");
    // R7/R8 mismatch sweep over each data and tag bit
    for (int b = 0; b < DW + TW; b++) begin
      int d0 = qd.size() > 0 ? qd[0] : 0;
      int t0 = qt.size() > 0 ? qt[0] : 0;
      if (qd.size() == 0) cyc(1, 3*b, b%8, 0, 0, 0, 0, "R2 refill");
      d0 = qd[0]; t0 = qt[0];
      if (b < DW) cyc(0, 0, 0, 1, d0 ^ (1 << b), t0, 0, "R7 data bit");
      else        cyc(0, 0, 0, 1, d0, t0 ^ (1 << (b-DW)), 0, "R7 tag bit");
      cyc(1, 1, 1, 1, d0, t0, 0, "R8 halted");
      cyc(1, 2, 2, 1, d0, t0, 0, "R8 halted");
      cyc(1, 9, 3, 1, d0, t0, 1, "R9 recover");
      cyc(1, 40+b, b%8, 0, 0, 0, 0, "R9 resume");
      cyc(0, 0, 0, 1, 40+b, b%8, 0, "R3 match");
    end
    // R7 both fields wrong
    cyc(1, 200, 6, 0, 0, 0, 0, "R2 push");
    cyc(0, 0, 0, 1, 201, 5, 0, "R7 both");
    cyc(0, 0, 0, 0, 0, 0, 0, "R8 idle");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9 recover");
    cyc(0, 0, 0, 1, 200, 6, 0, "R6 after flush");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule